// File: doc/BRIEF.md
# Indirect Register Write Sequencer

This block programs a demodulator's indirect register window through a simple byte-wide register transaction port. The transaction port is an abstract I2C register master: each request carries a 7-bit device address, an 8-bit register number, a read/write flag and a write byte. Each request is answered by a single response pulse that carries an ack/nack flag and a read byte. A start pulse latches a page number and a configuration buffer of `NBYTES` bytes. The block then runs a fixed program against the device: a readiness poll, the page select, the data bytes, the execute command, a completion poll and a read-back comparison.

When a step fails, the block abandons the current device address and moves to the next one. A step fails on a nack, on an exhausted poll or on a read-back difference. The candidate addresses are tried in a fixed order inside a bounded number of outer attempts. The block finishes with either a done flag and the address that accepted the whole program, or a fail flag.

Top module: `indirect_write_seq`

## Requirements
- R1: After reset, busy, done, fail and txn_req are low and good_addr is 0.
- R2: Each address attempt begins with readiness rounds, and each round is a read of 0xA2, then 0xA8, then 0xA4. The device counts as ready when bit 0 of the 0xA8 byte from that round is 1, and this is evaluated after the 0xA4 read. After 6 rounds without readiness, the address is abandoned.
- R3: Once the device is ready, the page byte is written to 0xA6. Then the NBYTES buffer bytes are written to 0xA7, one transaction each, byte 0 first; byte i is cfg_data[8i+7:8i].
- R4: After the data bytes, 0x03 is written to 0xA8.
- R5: The completion poll reads 0xA8 until bit 0 is 1, with at most 6 reads, and exhaustion abandons the address. Completion is followed by one read of 0xA2.
- R6: Next, 0xA7 is read NBYTES times and each byte is compared in order with the latched buffer. The first difference abandons the address.
- R7: A nack on any transaction abandons the current address at once, with no further transaction to it.
- R8: Addresses are tried in the order 0x10, 0x3F, 0x7F within each outer attempt, with 3 outer attempts, so at most 9 address attempts are made. Every new address attempt starts again from the readiness poll.
- R9: When the read-back matches completely, busy falls and done rises in the same cycle, and good_addr shows the accepting address. These stay until the next accepted start.
- R10: When all address attempts have failed, busy falls and fail rises with good_addr 0, and these hold until the next accepted start.
- R11: While busy, start is ignored. The page and buffer are captured at start, so changing them during a run has no effect on the bytes written or compared.
- R12: txn_req is high for exactly one cycle per transaction, only while busy. The next request is issued only after the response to the previous one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a programming run (ignored while busy) |
| page | input | 8 | Page number written to 0xA6 |
| cfg_data | input | 8*NBYTES | Configuration buffer, byte 0 in the low bits |
| busy | output | 1 | Run in progress |
| done | output | 1 | Last run succeeded |
| fail | output | 1 | Last run exhausted every address attempt |
| good_addr | output | 7 | Address that accepted the program |
| txn_req | output | 1 | One-cycle transaction request |
| txn_rd | output | 1 | 1 for a register read, 0 for a write |
| txn_dev | output | 7 | Device address of the request |
| txn_reg | output | 8 | Register number of the request |
| txn_wdata | output | 8 | Write byte of the request |
| txn_rsp | input | 1 | One-cycle response to the outstanding request |
| txn_nack | input | 1 | Response carries a nack |
| txn_rdata | input | 8 | Read byte of the response |

## Verification
The first run accepts every step at the first address, which fixes the baseline transaction order and data. Later runs mix faults to separate each abandonment path:
- an absent first address;
- a device that never reports ready;
- a read-back difference in the middle of the buffer;
- a command that never completes;
- a nack on the execute write;
- nacks at rising positions through the sequence.

A pass on the last address confirms the outer-attempt wrap. A run where every attempt fails on the final read-back byte confirms the fail outcome. Response latency varies per transaction. A second start pulse and altered buffer inputs during a run show that the captured values rule.

// File: rtl/indirect_write_seq.sv
module indirect_write_seq #(
  parameter int NBYTES   = 10,
  parameter int POLL_MAX = 6,
  parameter int TRIES    = 3,
  parameter logic [6:0] DEV0 = 7'h10,
  parameter logic [6:0] DEV1 = 7'h3F,
  parameter logic [6:0] DEV2 = 7'h7F,
  parameter logic [7:0] REG_STAT = 8'hA2,
  parameter logic [7:0] REG_LOCK = 8'hA4,
  parameter logic [7:0] REG_PAGE = 8'hA6,
  parameter logic [7:0] REG_DATA = 8'hA7,
  parameter logic [7:0] REG_CMD  = 8'hA8,
  parameter logic [7:0] CMD_EXEC = 8'h03
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [7:0]          page,
  input  logic [NBYTES*8-1:0] cfg_data,
  output logic                busy,
  output logic                done,
  output logic                fail,
  output logic [6:0]          good_addr,
  output logic                txn_req,
  output logic                txn_rd,
  output logic [6:0]          txn_dev,
  output logic [7:0]          txn_reg,
  output logic [7:0]          txn_wdata,
  input  logic                txn_rsp,
  input  logic                txn_nack,
  input  logic [7:0]          txn_rdata
);
  localparam int IW = (NBYTES > 1) ? $clog2(NBYTES) : 1;
  localparam int PW = $clog2(POLL_MAX + 1);
  localparam int AW = $clog2(TRIES + 1);
  localparam logic [IW-1:0] LAST_IDX  = IW'(NBYTES - 1);
  localparam logic [PW-1:0] LAST_POLL = PW'(POLL_MAX - 1);
  localparam logic [AW-1:0] LAST_TRY  = AW'(TRIES - 1);

  typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_WAIT} st_t;
  typedef enum logic [3:0] {P_RA2, P_RA8, P_RA4, P_PAGE, P_DATA, P_EXEC, P_CA8, P_CA2, P_VER} ph_t;

  st_t                 st;
  ph_t                 ph;
  logic [1:0]          slot;
  logic [AW-1:0]       att;
  logic [IW-1:0]       idx;
  logic [PW-1:0]       cnt;
  logic                rdy;
  logic [NBYTES*8-1:0] buf_q;
  logic [7:0]          page_q;
  logic                done_q, fail_q;
  logic [6:0]          good_q;
  logic [6:0]          cur_dev;
  logic [7:0]          cur_byte;
  logic                got, abandon;

  assign cur_dev  = (slot == 2'd0) ? DEV0 : (slot == 2'd1) ? DEV1 : DEV2;
  assign cur_byte = buf_q[{idx, 3'b000} +: 8];
  assign got      = (st == S_WAIT) && txn_rsp;

  assign busy      = (st != S_IDLE);
  assign done      = done_q;
  assign fail      = fail_q;
  assign good_addr = good_q;
  assign txn_req   = (st == S_ISSUE);
  assign txn_dev   = cur_dev;
  assign txn_rd    = !(ph inside {P_PAGE, P_DATA, P_EXEC});

  always_comb begin
    case (ph)
      P_RA2, P_CA2:  txn_reg = REG_STAT;
      P_RA4:         txn_reg = REG_LOCK;
      P_PAGE:        txn_reg = REG_PAGE;
      P_DATA, P_VER: txn_reg = REG_DATA;
      default:       txn_reg = REG_CMD;
    endcase
    case (ph)
      P_PAGE:  txn_wdata = page_q;
      P_DATA:  txn_wdata = cur_byte;
      P_EXEC:  txn_wdata = CMD_EXEC;
      default: txn_wdata = 8'h00;
    endcase
  end

  assign abandon = got && (txn_nack
                   || (ph == P_RA4 && !rdy && cnt == LAST_POLL)
                   || (ph == P_CA8 && !txn_rdata[0] && cnt == LAST_POLL)
                   || (ph == P_VER && txn_rdata != cur_byte));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;   ph <= P_RA2;  slot <= '0;  att <= '0;
      idx <= '0;      cnt <= '0;    rdy <= 1'b0;
      buf_q <= '0;    page_q <= '0;
      done_q <= 1'b0; fail_q <= 1'b0; good_q <= '0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          st <= S_ISSUE;  ph <= P_RA2;  slot <= '0;  att <= '0;
          idx <= '0;      cnt <= '0;    rdy <= 1'b0;
          buf_q <= cfg_data; page_q <= page;
          done_q <= 1'b0; fail_q <= 1'b0; good_q <= '0;
        end
        S_ISSUE: st <= S_WAIT;
        default: if (got) begin
          st <= S_ISSUE;
          if (abandon) begin
            ph <= P_RA2; idx <= '0; cnt <= '0; rdy <= 1'b0;
            if (slot == 2'd2) begin
              slot <= '0;
              if (att == LAST_TRY) begin
                st <= S_IDLE;
                fail_q <= 1'b1;
              end else begin
                att <= att + 1'b1;
              end
            end else begin
              slot <= slot + 1'b1;
            end
          end else begin
            case (ph)
              P_RA2: begin rdy <= 1'b0; ph <= P_RA8; end
              P_RA8: begin rdy <= txn_rdata[0]; ph <= P_RA4; end
              P_RA4:
                if (rdy) begin ph <= P_PAGE; cnt <= '0; end
                else begin cnt <= cnt + 1'b1; ph <= P_RA2; end
              P_PAGE: begin ph <= P_DATA; idx <= '0; end
              P_DATA:
                if (idx == LAST_IDX) begin ph <= P_EXEC; idx <= '0; end
                else idx <= idx + 1'b1;
              P_EXEC: begin ph <= P_CA8; cnt <= '0; end
              P_CA8:
                if (txn_rdata[0]) ph <= P_CA2;
                else cnt <= cnt + 1'b1;
              P_CA2: begin ph <= P_VER; idx <= '0; end
              default:
                if (idx == LAST_IDX) begin
                  st <= S_IDLE;
                  done_q <= 1'b1;
                  good_q <= cur_dev;
                end else begin
                  idx <= idx + 1'b1;
                end
            endcase
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/indirect_write_seq_chk.sv
module indirect_write_seq_chk #(
  parameter logic [6:0] A0 = 7'h10,
  parameter logic [6:0] A1 = 7'h3F,
  parameter logic [6:0] A2 = 7'h7F
) (
  input logic       clk,
  input logic       rst_n,
  input logic       busy,
  input logic       done,
  input logic       fail,
  input logic [6:0] good_addr,
  input logic       txn_req,
  input logic       txn_rd,
  input logic [6:0] txn_dev,
  input logic [7:0] txn_reg,
  input logic [7:0] txn_wdata
);
  p_req_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
    txn_req |=> !txn_req);
  p_req_busy_r12: assert property (@(posedge clk) disable iff (!rst_n)
    txn_req |-> busy);
  p_exec_code_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (txn_req && !txn_rd && txn_reg == 8'hA8) |-> txn_wdata == 8'h03);
  p_dev_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    txn_req |-> (txn_dev == A0 || txn_dev == A1 || txn_dev == A2));
  p_flags_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (!done && !fail));
  p_flags_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && fail));
  p_fail_addr_r10: assert property (@(posedge clk) disable iff (!rst_n)
    fail |-> good_addr == 7'h00);
  p_done_addr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (good_addr == A0 || good_addr == A1 || good_addr == A2));
  p_flags_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (done && $past(done) && !busy) |-> $stable(good_addr));
endmodule

bind indirect_write_seq indirect_write_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .fail(fail),
  .good_addr(good_addr), .txn_req(txn_req), .txn_rd(txn_rd),
  .txn_dev(txn_dev), .txn_reg(txn_reg), .txn_wdata(txn_wdata)
);

// File: tb/indirect_write_seq_bench.sv
module indirect_write_seq_bench;
  localparam int NB = 10;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [7:0] page = 8'h00;
  logic [NB*8-1:0] cfg = '0;
  logic busy, done, fail, txn_req, txn_rd;
  logic [6:0] good_addr, txn_dev;
  logic [7:0] txn_reg, txn_wdata;
  logic txn_rsp = 1'b0, txn_nack = 1'b0;
  logic [7:0] txn_rdata = 8'h00;

  always #10 clk = ~clk;

  indirect_write_seq #(.NBYTES(NB)) u_indirect_write_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .page(page), .cfg_data(cfg),
    .busy(busy), .done(done), .fail(fail), .good_addr(good_addr),
    .txn_req(txn_req), .txn_rd(txn_rd), .txn_dev(txn_dev), .txn_reg(txn_reg),
    .txn_wdata(txn_wdata), .txn_rsp(txn_rsp), .txn_nack(txn_nack), .txn_rdata(txn_rdata));

  typedef struct {
    bit rd; logic [6:0] dev; logic [7:0] rg; logic [7:0] wd;
    bit nk; logic [7:0] rdat; string tag;
  } txn_t;

  txn_t q[$];
  txn_t cur;
  int ra[9], da[9], na[9], ma[9];
  int cmp_n = 0, bad_n = 0, cycles = 0, ntx = 0, cd = 0;
  bit armed = 0, go = 0, poke = 0, poke_ph = 0, start_ph = 0;
  bit outstanding = 0, final_pending = 0, fin_flag = 0;
  bit exp_busy = 0, exp_done = 0, exp_fail = 0;
  logic [6:0] exp_addr = '0;
  bit fin_done, fin_fail;
  logic [6:0] fin_addr;

  function automatic logic [6:0] dev_of(int s);
    return (s % 3 == 0) ? 7'h10 : (s % 3 == 1) ? 7'h3F : 7'h7F;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    cmp_n++;
    if (act !== exp) begin
      bad_n++;
      $display("FAIL %s actual=%0h expected=%0h at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  task automatic add(bit rd, logic [7:0] rg, logic [7:0] wd, logic [7:0] rdat,
                     string tag, int s, inout int t, inout bit dead);
    txn_t e;
    if (dead) return;
    e.rd = rd; e.dev = dev_of(s); e.rg = rg; e.wd = wd; e.rdat = rdat; e.tag = tag;
    e.nk = (t == na[s]);
    q.push_back(e);
    t++;
    if (e.nk) dead = 1;
  endtask

  // Reference: transactions and outcome derived from R2..R10
  task automatic build();
    bit ok, dead;
    int t;
    q.delete();
    fin_done = 0; fin_fail = 1; fin_addr = 7'h00;
    for (int s = 0; s < 9; s++) begin
      dead = 0; t = 0; ok = 0;
      for (int r = 0; r < 6; r++) begin
        add(1, 8'hA2, 8'h00, 8'h5A, "R2", s, t, dead);
        add(1, 8'hA8, 8'h00, (r >= ra[s]) ? 8'h01 : 8'h00, "R2", s, t, dead);
        add(1, 8'hA4, 8'h00, 8'h20, "R2", s, t, dead);
        if (dead) break;
        if (r >= ra[s]) begin ok = 1; break; end
      end
      if (!ok || dead) continue;
      add(0, 8'hA6, page, 8'h00, "R3", s, t, dead);
      for (int i = 0; i < NB; i++) add(0, 8'hA7, cfg[8*i +: 8], 8'h00, "R3", s, t, dead);
      add(0, 8'hA8, 8'h03, 8'h00, "R4", s, t, dead);
      ok = 0;
      for (int c = 0; c < 6; c++) begin
        add(1, 8'hA8, 8'h00, (c >= da[s]) ? 8'h01 : 8'h00, "R5", s, t, dead);
        if (dead) break;
        if (c >= da[s]) begin ok = 1; break; end
      end
      if (!ok || dead) continue;
      add(1, 8'hA2, 8'h00, 8'h5A, "R5", s, t, dead);
      for (int i = 0; i < NB; i++) begin
        add(1, 8'hA7, 8'h00, cfg[8*i +: 8] ^ ((i == ma[s]) ? 8'h40 : 8'h00), "R6", s, t, dead);
        if (dead) break;
        if (i == ma[s]) begin ok = 0; break; end
      end
      if (dead || !ok) continue;
      fin_done = 1; fin_fail = 0; fin_addr = dev_of(s);
      break;
    end
  endtask

  task automatic clear_slots();
    for (int s = 0; s < 9; s++) begin ra[s] = 0; da[s] = 0; na[s] = -1; ma[s] = -1; end
  endtask

  always @(negedge clk) begin
    if (armed) begin
      cycles++;
      if (cycles > 100000) begin
        bad_n++;
        $display("FAIL watchdog: run hung, actual=busy expected=idle");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", cmp_n, bad_n);
        $finish;
      end
      if (final_pending) begin
        exp_busy = 0; exp_done = fin_done; exp_fail = fin_fail; exp_addr = fin_addr;
        final_pending = 0; fin_flag = 1;
      end
      if (start_ph) begin
        start = 0; start_ph = 0;
        exp_busy = 1; exp_done = 0; exp_fail = 0; exp_addr = 7'h00;
      end
      if (poke_ph) begin start = 0; poke_ph = 0; end
      chk("R9 busy", busy, exp_busy);
      if (!exp_busy) begin
        chk("R9 done", done, exp_done);
        chk("R10 fail", fail, exp_fail);
        chk("R9 good_addr", good_addr, exp_addr);
      end
      if (txn_rsp) txn_rsp = 0;
      if (txn_req) begin
        if (outstanding) begin
          bad_n++;
          $display("FAIL R12 request while outstanding actual=1 expected=0");
        end
        if (q.size() == 0) begin
          bad_n++;
          $display("FAIL R7 unexpected request actual=%0h/%0h expected=none", txn_dev, txn_reg);
        end else begin
          cur = q.pop_front();
          chk({cur.tag, " rd"}, txn_rd, cur.rd);
          chk("R8 dev", txn_dev, cur.dev);
          chk({cur.tag, " reg"}, txn_reg, cur.rg);
          if (!cur.rd) chk({cur.tag, " wdata"}, txn_wdata, cur.wd);
          outstanding = 1;
          cd = 1 + (ntx % 3);
          ntx++;
        end
      end else if (outstanding) begin
        cd--;
        if (cd == 0) begin
          txn_rsp = 1; txn_nack = cur.nk; txn_rdata = cur.rdat;
          outstanding = 0;
          if (q.size() == 0) final_pending = 1;
        end
      end
      if (go) begin go = 0; start = 1; start_ph = 1; end
      // R11: a start pulse during a run must change nothing
      if (poke) begin poke = 0; start = 1; poke_ph = 1; end
    end
  end

  task automatic run_one();
    build();
    @(posedge clk); go = 1;
    wait (fin_flag == 1);
    fin_flag = 0;
    repeat (3) @(posedge clk);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 busy", busy, 0);
    chk("R1 done", done, 0);
    chk("R1 fail", fail, 0);
    chk("R1 txn_req", txn_req, 0);
    chk("R1 good_addr", good_addr, 0);
    armed = 1;

    // S1: first address accepts everything
    clear_slots();
    for (int i = 0; i < NB; i++) cfg[8*i +: 8] = 8'(i * 17 + 1);
    page = 8'h00;
    run_one();

    // S2: absent first device (R7), slow ready and slow completion on the second
    clear_slots();
    na[0] = 0; ra[1] = 2; da[1] = 3;
    for (int i = 0; i < NB; i++) cfg[8*i +: 8] = 8'(8'hA0 + i);
    page = 8'h05;
    run_one();

    // S3: never ready, mismatch, never complete, execute nack (R7), then success
    clear_slots();
    ra[0] = 6; ma[1] = 4; da[2] = 6; na[3] = 14;
    for (int i = 0; i < NB; i++) cfg[8*i +: 8] = 8'(i * 37 + 11);
    page = 8'h3C;
    build();
    @(posedge clk); go = 1;
    repeat (40) @(posedge clk);
    poke = 1;              // R11 second start while busy
    cfg = ~cfg; page = 8'hFF;
    wait (fin_flag == 1);
    fin_flag = 0;
    repeat (3) @(posedge clk);

    // S4: nacks at rising positions (R7), last address of last attempt succeeds (R8)
    clear_slots();
    for (int s = 0; s < 8; s++) na[s] = s * 3;
    ra[8] = 5; da[8] = 5;
    for (int i = 0; i < NB; i++) cfg[8*i +: 8] = (i % 2 == 0) ? 8'h00 : 8'hFF;
    page = 8'h01;
    run_one();

    // S5: every attempt differs on the final read-back byte (R6, R10)
    clear_slots();
    for (int s = 0; s < 9; s++) ma[s] = NB - 1;
    for (int i = 0; i < NB; i++) cfg[8*i +: 8] = 8'(8'hC3 ^ i);
    page = 8'h00;
    run_one();

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", cmp_n, bad_n);
    $finish;
  end
endmodule